// File: doc/BRIEF.md
# IR Pulse-Width Capture Receiver

This block times the marks and spaces on an already demodulated infrared input line. A 16-bit prescaler divides the reference clock into ticks for an 18-bit pulse-width timer. On every qualifying edge of the filtered input, the timer value and the level of the interval that just ended are written into an 8-entry receive FIFO. The timer then restarts. A glitch filter removes pulses shorter than a programmed window. An edge selector chooses which transitions end a measurement.

When no edge arrives before the timer reaches its ceiling, the block writes a timeout entry into the FIFO. This marks the end of a transmission. A host reads entries one pop at a time. Each pop says whether it returned real data. Overrun and timeout are recorded in sticky status bits. Each one is cleared by turning its enable off and then on again. Three interrupt outputs are available, each with its own enable: FIFO service, timeout and overrun.

Top module: `irrx_capture`

## Requirements
- R1: One timer tick lasts `div_val + 1` clocks. The timer restarts at each counted edge. An edge that ends an interval of H clocks stores a width of `floor((H-1)/(div_val+1)) >> 2`. This is the timer's upper `TMR_W-2` bits, and the two low bits are dropped.
- R2: Each entry's level bit is the input level during the measured interval: 1 for high, 0 for low.
- R3: If the timer reaches its all-ones value with no counted edge, one entry is pushed with `rd_tmo`=1 and an all-ones width. This also sets `sts_tmo`.
- R4: After a timeout the timer holds at all ones, and no further timeout entry is pushed. The next counted edge pushes an all-ones width with `rd_tmo`=0.
- R5: A pop returns `rd_valid`=1 with the oldest entry when the FIFO holds data. On an empty FIFO it returns `rd_valid`=0, and the level, marker and width read as zero. The result appears the cycle after `pop`.
- R6: A push into a full FIFO is dropped and sets `sts_ovr`. `sts_ovr` stays set until `fifo_en` goes from 0 to 1. While `fifo_en` is 0 the FIFO is held empty.
- R7: `sts_tmo` stays set, even across pops and further edges, until `rx_en` goes from 0 to 1.
- R8: With `filt_cnt`=N≥2, an input pulse shorter than N clocks produces no entry, and a longer pulse is measured at its true width. N of 0 or 1 turns filtering off.
- R9: `edge_sel` encoding: 0 counts no edges and also stops the timer, so there are no entries and no timeouts; 1 counts rising edges; 2 counts falling edges; 3 counts both.
- R10: `irq_svc` = `svc_ie` and (`fifo_count` ≥ 4). `irq_tmo` = `tmo_ie` and `sts_tmo`. `irq_ovr` = `ovr_ie` and `sts_ovr`.
- R11: The FIFO holds 8 entries, and `fifo_count` reports its occupancy.
- R12: After reset the FIFO is empty and both status bits and all interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated IR line, asynchronous |
| rx_en | input | 1 | Receiver enable; a 0→1 transition clears `sts_tmo` |
| fifo_en | input | 1 | FIFO enable; 0 empties the FIFO, and a 0→1 transition clears `sts_ovr` |
| edge_sel | input | 2 | Edge mode: 0 none, 1 rising, 2 falling, 3 both |
| div_val | input | DIV_W (16) | Prescaler reload value |
| filt_cnt | input | FLT_W (16) | Glitch rejection window in clocks |
| svc_ie | input | 1 | Service interrupt enable |
| tmo_ie | input | 1 | Timeout interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| pop | input | 1 | Read one entry |
| rd_valid | output | 1 | Last pop returned a queued entry |
| rd_tmo | output | 1 | Last entry was a timeout marker |
| rd_level | output | 1 | Level of the measured interval |
| rd_width | output | TMR_W-2 (16) | Measured width in units of 4 ticks |
| fifo_count | output | clog2(DEPTH+1) (4) | FIFO occupancy |
| sts_tmo | output | 1 | Sticky receive timeout |
| sts_ovr | output | 1 | Sticky FIFO overrun |
| irq_svc | output | 1 | FIFO service request |
| irq_tmo | output | 1 | Timeout interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The bench derives expected widths from the tick arithmetic at several divider values. An off-by-one in the prescaler reload or in the restart would show up as widths that are one quantum off or that scale wrongly with the divider. The timeout tests check three things: a single marker entry, a held timer, and a status bit that survives everything except an enable toggle. A design that wrapped the timer would queue repeated timeout entries or small widths. A design that cleared status on a pop or on the next edge would drop `sts_tmo` early. The bench also covers rejection of short glitches, the no-edge mode staying silent, rising-only measurement of whole periods, the watermark boundary between three and four entries, and a ninth push into a full FIFO. A design that mishandled these would queue glitches, time out while idle, or miss the overrun.

// File: rtl/irrx_pkg.sv
// Shared definitions for the IR pulse-width capture receiver.
package irrx_pkg;
    // Encoding of the edge selection field.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;
endpackage

// File: rtl/irrx_glitch_filter.sv
// Synchronises the raw IR line and rejects pulses shorter than win_i clocks.
// Assumes raw_i is asynchronous; both edges see the same delay, so widths
// of accepted pulses are preserved.
module irrx_glitch_filter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] win_i,
    output logic             lvl_o
);
    logic [1:0]       sync_q;
    logic             lvl_q;
    logic [CNT_W-1:0] run_q;
    logic             pass;

    // Accept the new level once it has persisted for the whole window.
    always_comb pass = (win_i <= CNT_W'(1)) || (run_q >= win_i - CNT_W'(1));

    // Two-stage synchroniser followed by the persistence counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            lvl_q  <= 1'b0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == lvl_q) begin
                run_q <= '0;
            end else if (pass) begin
                lvl_q <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/irrx_width_timer.sv
// Prescaled, saturating pulse-width timer with edge qualification and
// timeout generation. Produces one push request per counted edge or timeout.
// Assumes lvl_i is synchronous and filtered.
module irrx_width_timer
    import irrx_pkg::*;
#(
    parameter int TMR_W = 18,
    parameter int DIV_W = 16,
    localparam int WID_W = TMR_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             lvl_i,
    output logic             push_o,
    output logic             push_tmo_o,
    output logic             push_lvl_o,
    output logic [WID_W-1:0] push_width_o
);
    localparam logic [TMR_W-1:0] TMR_TOP  = '1;
    localparam logic [TMR_W-1:0] TMR_NEAR = TMR_TOP - TMR_W'(1);

    edge_mode_e       mode;
    logic             lvl_q;
    logic [DIV_W-1:0] pre_q;
    logic [TMR_W-1:0] tmr_q;
    logic             running, hit, counted, tick, tmo_hit;

    // Decode which transitions end a measurement.
    always_comb begin
        mode    = edge_mode_e'(edge_sel_i);
        running = rx_en_i && (mode != EDGE_NONE);
        unique case (mode)
            EDGE_RISE: hit = lvl_i & ~lvl_q;
            EDGE_FALL: hit = ~lvl_i & lvl_q;
            EDGE_BOTH: hit = lvl_i ^ lvl_q;
            default:   hit = 1'b0;
        endcase
        counted = running && hit;
        tick    = (pre_q == '0);
        tmo_hit = running && !counted && tick && (tmr_q == TMR_NEAR);
    end

    // Form the push request and the entry fields.
    always_comb begin
        push_o       = counted || tmo_hit;
        push_tmo_o   = tmo_hit;
        push_lvl_o   = counted ? lvl_q : lvl_i;
        push_width_o = tmo_hit ? '1 : tmr_q[TMR_W-1:2];
    end

    // Prescaler reload, timer increment with saturation, restart on edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            pre_q <= '0;
            tmr_q <= '0;
        end else begin
            lvl_q <= lvl_i;
            if (!running || counted) begin
                pre_q <= div_i;
                tmr_q <= '0;
            end else if (tick) begin
                pre_q <= div_i;
                if (tmr_q != TMR_TOP) tmr_q <= tmr_q + TMR_W'(1);
            end else begin
                pre_q <= pre_q - DIV_W'(1);
            end
        end
    end

    // R4: a saturated timer holds until an edge.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q == TMR_TOP && running && !counted) |=> (tmr_q == TMR_TOP));
    // R3: a timeout entry always carries an all-ones width.
    a_r3_tmo_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && push_tmo_o) |-> (&push_width_o));
    // R9: the no-edge mode never requests a push.
    a_r9_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'd0) |-> !push_o);
endmodule

// File: rtl/irrx_fifo.sv
// Receive FIFO with registered read port and overrun detection.
// Assumes DEPTH is a power of two; en_i low holds it empty.
module irrx_fifo #(
    parameter int ENT_W = 18,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             push_i,
    input  logic [ENT_W-1:0] data_i,
    input  logic             pop_i,
    output logic             rd_valid_o,
    output logic [ENT_W-1:0] rd_data_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             has_data, full, do_pop, do_push;

    // Accept or refuse the requests of this cycle.
    always_comb begin
        has_data = (cnt_q != '0);
        full     = (cnt_q == CNT_W'(DEPTH));
        do_pop   = en_i && pop_i && has_data;
        do_push  = en_i && push_i && (!full || do_pop);
        ovf_o    = en_i && push_i && full && !do_pop;
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= data_i;
    end

    // Pointers and occupancy, emptied while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + PTR_W'(1);
            if (do_pop)  rd_q <= rd_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Registered read result with its validity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else if (pop_i) begin
            rd_valid_o <= do_pop;
            rd_data_o  <= do_pop ? mem[rd_q] : '0;
        end
    end

    assign count_o = cnt_q;

    // R11: occupancy never exceeds the depth.
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R5: popping an empty FIFO yields no valid data.
    a_r5_empty_pop_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q == '0) |=> (!rd_valid_o && rd_data_o == '0));
endmodule

// File: rtl/irrx_capture.sv
// IR pulse-width capture receiver top: filter, timer, FIFO, sticky status
// and interrupts. Assumes ir_in is an asynchronous demodulated line.
module irrx_capture #(
    parameter int TMR_W = 18,
    parameter int DIV_W = 16,
    parameter int FLT_W = 16,
    parameter int DEPTH = 8,
    parameter int WMARK = 4,
    localparam int WID_W = TMR_W - 2,
    localparam int ENT_W = WID_W + 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_in,
    input  logic             rx_en,
    input  logic             fifo_en,
    input  logic [1:0]       edge_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic [FLT_W-1:0] filt_cnt,
    input  logic             svc_ie,
    input  logic             tmo_ie,
    input  logic             ovr_ie,
    input  logic             pop,
    output logic             rd_valid,
    output logic             rd_tmo,
    output logic             rd_level,
    output logic [WID_W-1:0] rd_width,
    output logic [CNT_W-1:0] fifo_count,
    output logic             sts_tmo,
    output logic             sts_ovr,
    output logic             irq_svc,
    output logic             irq_tmo,
    output logic             irq_ovr
);
    logic             lvl;
    logic             push, push_tmo, push_lvl, ovf;
    logic [WID_W-1:0] push_width;
    logic [ENT_W-1:0] rd_data;
    logic             rx_en_q, fifo_en_q, rx_rise, fifo_rise;

    irrx_glitch_filter #(.CNT_W(FLT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(ir_in), .win_i(filt_cnt), .lvl_o(lvl)
    );

    irrx_width_timer #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .edge_sel_i(edge_sel),
        .div_i(div_val), .lvl_i(lvl), .push_o(push), .push_tmo_o(push_tmo),
        .push_lvl_o(push_lvl), .push_width_o(push_width)
    );

    irrx_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .en_i(fifo_en), .push_i(push),
        .data_i({push_tmo, push_lvl, push_width}), .pop_i(pop),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .count_o(fifo_count),
        .ovf_o(ovf)
    );

    // Detect the re-enable transitions that clear the sticky bits.
    always_comb begin
        rx_rise   = rx_en && !rx_en_q;
        fifo_rise = fifo_en && !fifo_en_q;
    end

    // Sticky status, cleared only by an enable toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q   <= 1'b0;
            fifo_en_q <= 1'b0;
            sts_tmo   <= 1'b0;
            sts_ovr   <= 1'b0;
        end else begin
            rx_en_q   <= rx_en;
            fifo_en_q <= fifo_en;
            if (rx_rise)                    sts_tmo <= 1'b0;
            else if (push && push_tmo)      sts_tmo <= 1'b1;
            if (fifo_rise)                  sts_ovr <= 1'b0;
            else if (ovf)                   sts_ovr <= 1'b1;
        end
    end

    // Unpack the read entry and gate the interrupts.
    always_comb begin
        rd_tmo   = rd_data[ENT_W-1];
        rd_level = rd_data[ENT_W-2];
        rd_width = rd_data[WID_W-1:0];
        irq_svc  = svc_ie && (fifo_count >= CNT_W'(WMARK));
        irq_tmo  = tmo_ie && sts_tmo;
        irq_ovr  = ovr_ie && sts_ovr;
    end

    // R6: overrun status survives until the FIFO enable is toggled.
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ovr && !fifo_rise) |=> sts_ovr);
    // R7: timeout status survives until the receiver enable is toggled.
    a_r7_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_tmo && !rx_rise) |=> sts_tmo);
endmodule

// File: tb/irrx_capture_tb.sv
module irrx_capture_tb;
    localparam int TW = 12;
    localparam int WW = TW - 2;
    localparam int WMAX = (1 << WW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_in = 1'b0, rx_en = 1'b0, fifo_en = 1'b0;
    logic [1:0] edge_sel = 2'd3;
    logic [15:0] div_val = '0, filt_cnt = '0;
    logic svc_ie = 1'b1, tmo_ie = 1'b1, ovr_ie = 1'b1, pop = 1'b0;
    logic rd_valid, rd_tmo, rd_level;
    logic [WW-1:0] rd_width;
    logic [3:0] fifo_count;
    logic sts_tmo, sts_ovr, irq_svc, irq_tmo, irq_ovr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irrx_capture #(.TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .rx_en(rx_en), .fifo_en(fifo_en),
        .edge_sel(edge_sel), .div_val(div_val), .filt_cnt(filt_cnt),
        .svc_ie(svc_ie), .tmo_ie(tmo_ie), .ovr_ie(ovr_ie), .pop(pop),
        .rd_valid(rd_valid), .rd_tmo(rd_tmo), .rd_level(rd_level),
        .rd_width(rd_width), .fifo_count(fifo_count), .sts_tmo(sts_tmo),
        .sts_ovr(sts_ovr), .irq_svc(irq_svc), .irq_tmo(irq_tmo), .irq_ovr(irq_ovr)
    );

    // Vectors: divider, high time, low time (clocks).
    localparam int VEC [5][3] = '{
        '{0, 40, 60}, '{1, 80, 50}, '{3, 200, 120}, '{2, 97, 150}, '{0, 43, 41}
    };

    function automatic int exp_w(input int h, input int d);
        int t;
        t = ((h - 1) / (d + 1)) >> 2;
        return (t > WMAX) ? WMAX : t;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic flush();
        @(negedge clk) fifo_en = 1'b0;
        @(negedge clk) fifo_en = 1'b1;
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R12: reset state
        chk("R12", "count", fifo_count, 0);
        chk("R12", "sts", {sts_tmo, sts_ovr}, 0);
        chk("R12", "irq", {irq_svc, irq_tmo, irq_ovr}, 0);
        // R5: empty pop is invalid
        do_pop();
        chk("R5", "empty valid", rd_valid, 0);
        chk("R5", "empty data", {rd_tmo, rd_level, rd_width}, 0);

        rx_en = 1'b1;
        fifo_en = 1'b1;
        wait_n(20);

        // R1 R2: table of mark/space widths at several dividers
        for (int v = 0; v < 5; v++) begin
            div_val = 16'(VEC[v][0]);
            @(negedge clk) ir_in = 1'b1;
            wait_n(8);
            flush();
            wait_n(VEC[v][1] - 10);
            ir_in = 1'b0;
            wait_n(VEC[v][2]);
            ir_in = 1'b1;
            wait_n(8);
            chk("R11", "count after pair", fifo_count, 2);
            do_pop();
            chk("R5", "mark valid", rd_valid, 1);
            chk("R2", "mark level", rd_level, 1);
            chk("R1", "mark width", rd_width, exp_w(VEC[v][1], VEC[v][0]));
            do_pop();
            chk("R2", "space level", rd_level, 0);
            chk("R1", "space width", rd_width, exp_w(VEC[v][2], VEC[v][0]));
            @(negedge clk) ir_in = 1'b0;
            wait_n(30);
        end

        // R8: glitch filter
        div_val = 16'd0;
        filt_cnt = 16'd20;
        flush();
        wait_n(5);
        @(negedge clk) ir_in = 1'b1;
        wait_n(10);
        ir_in = 1'b0;
        wait_n(40);
        chk("R8", "glitch ignored", fifo_count, 0);
        ir_in = 1'b1;
        wait_n(30);
        ir_in = 1'b0;
        wait_n(40);
        chk("R8", "long pulse entries", fifo_count, 2);
        do_pop();
        do_pop();
        chk("R8", "long pulse level", rd_level, 1);
        chk("R8", "long pulse width", rd_width, exp_w(30, 0));
        filt_cnt = 16'd0;

        // R9: rising-only measures whole periods
        edge_sel = 2'd1;
        @(negedge clk) ir_in = 1'b1;
        wait_n(8);
        flush();
        wait_n(30);
        ir_in = 1'b0;
        wait_n(60);
        ir_in = 1'b1;
        wait_n(8);
        chk("R9", "rise count", fifo_count, 1);
        do_pop();
        chk("R9", "rise level", rd_level, 0);
        chk("R9", "rise width", rd_width, exp_w(100, 0));
        @(negedge clk) ir_in = 1'b0;
        wait_n(30);

        // R9: no-edge mode stays silent
        edge_sel = 2'd0;
        flush();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) ir_in = ~ir_in;
            wait_n(20);
        end
        wait_n(4500);
        chk("R9", "none mode entries", fifo_count, 0);

        // R3 R4 R7: timeout
        edge_sel = 2'd3;
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        flush();
        wait_n(2);
        chk("R7", "cleared by toggle", sts_tmo, 0);
        wait_n(3000);
        chk("R3", "no early timeout", fifo_count, 0);
        wait_n(1500);
        chk("R3", "timeout entry", fifo_count, 1);
        chk("R3", "timeout status", sts_tmo, 1);
        chk("R10", "tmo irq", irq_tmo, 1);
        wait_n(3000);
        chk("R4", "no repeat timeout", fifo_count, 1);
        @(negedge clk) ir_in = 1'b1;
        wait_n(8);
        chk("R4", "edge after timeout", fifo_count, 2);
        do_pop();
        chk("R3", "marker", rd_tmo, 1);
        chk("R3", "marker width", rd_width, WMAX);
        do_pop();
        chk("R4", "saturated marker", rd_tmo, 0);
        chk("R4", "saturated width", rd_width, WMAX);
        chk("R7", "sticky after pops", sts_tmo, 1);
        @(negedge clk) tmo_ie = 1'b0;
        #1;
        chk("R10", "tmo irq gated", irq_tmo, 0);
        tmo_ie = 1'b1;
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        wait_n(2);
        chk("R7", "cleared after toggle", sts_tmo, 0);

        // R6 R10 R11: watermark and overrun
        flush();
        wait_n(2);
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk) ir_in = ~ir_in;
            wait_n(20);
            if (i == 3) chk("R10", "svc below mark", irq_svc, 0);
            if (i == 4) chk("R10", "svc at mark", irq_svc, 1);
            if (i == 8) chk("R6", "no ovr when just full", sts_ovr, 0);
        end
        chk("R11", "full count", fifo_count, 8);
        chk("R6", "overrun status", sts_ovr, 1);
        chk("R10", "ovr irq", irq_ovr, 1);
        for (int i = 0; i < 8; i++) do_pop();
        chk("R6", "sticky after drain", sts_ovr, 1);
        flush();
        wait_n(2);
        chk("R6", "cleared by toggle", sts_ovr, 0);
        chk("R6", "flushed", fifo_count, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule